// File: doc/BRIEF.md
# EDO DRAM Strobe-Driven Memory Emulator

This block models the data path of a small word-wide EDO DRAM behind a set of active-low strobes: a row strobe, two column strobes (one per byte lane), a write enable and an output enable. A fast system clock samples the strobes, which arrive already synchronous to it. Every strobe edge is found by comparing the present level with the level held from the previous clock. The row address is taken when the row strobe falls. The column address is taken when the first column strobe of a column cycle falls. Each byte lane then runs a read, an early write or a late write on its own.

A read lane drives its byte through a per-lane output enable. It keeps driving after its column strobe rises, as extended-data-out reads do, until the row strobe rises or write enable goes low. An early write keeps the lane in high impedance whatever the output enable does. A late write is refused while the output enable is still low, and the lane then goes on driving the stored byte. If the two lanes use different modes inside one column cycle, a sticky error flag is raised and the offending lane's write is dropped. The array has 256 words of 16 bits, addressed by a 4-bit row and a 4-bit column, and it clears to zero on reset.

Top module: `edo_dram_emu`

## Requirements
- R1: After reset every word reads as zero, both lane enables are low, `dq_o` is zero and `proto_err_o` is low.
- R2: The row is taken from `addr_i` on the clock where `ras_ni` is first seen low. The column is taken on the clock where a column strobe falls after both were high. Each new column cycle inside one row-strobe low period takes a new column (page mode).
- R3: A column strobe that falls while `we_ni` is high starts a read. From the next clock, while `oe_ni` and `ras_ni` are low, the lane drives the stored byte. Lane 0 is `casl_ni`, `dq_o[7:0]` and `dq_oe_o[0]`. Lane 1 is `cash_ni`, `dq_o[15:8]` and `dq_oe_o[1]`.
- R4: A lane whose column strobe stays high is neither driven nor written.
- R5: A column strobe that falls while `we_ni` is low writes that lane's `dq_i` byte from that clock, and the lane stays undriven even with `oe_ni` low.
- R6: When `we_ni` falls while the lane's column strobe is low after a read start and `oe_ni` is high, the `dq_i` byte of that clock is written.
- R7: If `we_ni` falls in that situation while `oe_ni` is low, nothing is written and the lane keeps driving the stored byte.
- R8: After the column strobe rises, read data stays driven while `ras_ni` and `oe_ni` are low and `we_ni` is high. It is released when `ras_ni` rises or `we_ni` goes low.
- R9: During a read, raising `oe_ni` puts the lane in high impedance and lowering it drives the data again.
- R10: Different modes on the two lanes within one column cycle (both strobes never high together in between) set `proto_err_o`, which stays set until reset, and the conflicting lane is not written. An early write on one lane and a late write on the other are accepted without error when both strobes were high between them.
- R11: `dq_o` bits of an undriven lane read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the strobes |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| casl_ni | input | 1 | Lower-lane column strobe, active low |
| cash_ni | input | 1 | Upper-lane column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | 4 | Multiplexed row/column address |
| dq_i | input | 16 | Write data |
| dq_o | output | 16 | Read data, zero on undriven lanes |
| dq_oe_o | output | 2 | Per-lane output enable |
| proto_err_o | output | 1 | Sticky mixed-mode error |

## Verification
The hardest case to reach is a mode conflict between the lanes. One lane has to start a read and turn it into a late write, and then the other column strobe has to fall with write enable already low, all before either strobe rises. The stimulus builds this step by step with one strobe change per clock. It runs the same sequence again with a strobe precharge placed between the two lanes, so that both the flagged case and the allowed case are covered. The refused late write is reached the same way, by dropping write enable while the output enable is still low in the middle of a read.

// File: rtl/edo_dram_pkg.sv
package edo_dram_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_READ  = 2'd1,
    MODE_EARLY = 2'd2,
    MODE_LATE  = 2'd3
  } lane_mode_e;
endpackage

// File: rtl/edo_strobe_sampler.sv
module edo_strobe_sampler #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] strobe_ni,
  output logic [W-1:0] prev_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_o <= '1;
    else         prev_o <= strobe_ni;
  end
endmodule

// File: rtl/edo_lane_bank.sv
module edo_lane_bank #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/edo_lane_ctrl.sv
module edo_lane_ctrl
  import edo_dram_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              cas_fall_i,
  input  logic              we_ni,
  input  logic              we_fall_i,
  input  logic              oe_ni,
  input  logic              precharge_i,
  input  lane_mode_e        peer_mode_i,
  input  logic [BYTE_W-1:0] mem_rd_i,
  output lane_mode_e        mode_o,
  output logic              wr_en_o,
  output logic              conflict_o,
  output logic              drive_o,
  output logic [BYTE_W-1:0] rd_data_o
);
  lane_mode_e        mode_q;
  logic              rd_valid_q;
  logic [BYTE_W-1:0] rd_q;
  logic              early, rd_start, late_try, late;
  logic              peer_is_rd, peer_is_early;

  assign early    = cas_fall_i & ~we_ni;
  assign rd_start = cas_fall_i & we_ni;
  // write enable falls inside an open read column cycle
  assign late_try = ~cas_ni & ~ras_ni & we_fall_i & ~cas_fall_i & (mode_q == MODE_READ);
  assign late     = late_try & oe_ni;

  assign peer_is_rd    = (peer_mode_i == MODE_READ) || (peer_mode_i == MODE_LATE);
  assign peer_is_early = (peer_mode_i == MODE_EARLY);

  assign conflict_o = (early & peer_is_rd) | ((rd_start | late) & peer_is_early);
  assign wr_en_o    = (early | late) & ~conflict_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_IDLE;
    end else if (rd_start) begin
      mode_q <= MODE_READ;
    end else if (early) begin
      mode_q <= MODE_EARLY;
    end else if (late) begin
      mode_q <= MODE_LATE;
    end else if (precharge_i) begin
      mode_q <= MODE_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_q       <= '0;
    end else if (rd_start) begin
      rd_valid_q <= 1'b1;
      rd_q       <= mem_rd_i;
    end else if (ras_ni || early || late || (!we_ni && cas_ni)) begin
      rd_valid_q <= 1'b0;
    end
  end

  // extended data out: held past strobe rise until row strobe or write enable release it
  assign drive_o   = rd_valid_q & ~oe_ni & ~ras_ni & (we_ni | ~cas_ni);
  assign rd_data_o = rd_q;
  assign mode_o    = mode_q;

  p_early_hiz_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_EARLY && !cas_ni) |-> !drive_o);

  p_wr_cas_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !cas_ni);

  p_late_oe_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !cas_fall_i) |-> oe_ni);
endmodule

// File: rtl/edo_dram_emu.sv
module edo_dram_emu
  import edo_dram_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        ras_ni,
  input  logic                        casl_ni,
  input  logic                        cash_ni,
  input  logic                        we_ni,
  input  logic                        oe_ni,
  input  logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] addr_i,
  input  logic [2*BYTE_W-1:0]         dq_i,
  output logic [2*BYTE_W-1:0]         dq_o,
  output logic [1:0]                  dq_oe_o,
  output logic                        proto_err_o
);
  localparam int LANES = 2;
  localparam int AW    = ROW_W + COL_W;
  localparam int NSTB  = 4;

  logic [NSTB-1:0]  stb_n, stb_prev;
  logic             ras_prev, we_prev, ras_fall, we_fall;
  logic [LANES-1:0] cas_n, cas_prev, cas_fall;
  logic             col_load, precharge;
  logic [ROW_W-1:0] row_q, row_eff;
  logic [COL_W-1:0] col_q, col_eff;
  logic [AW-1:0]    acc_addr;
  logic [LANES-1:0] conflict, drive;
  lane_mode_e       lane_mode [LANES];

  assign stb_n = {we_ni, cash_ni, casl_ni, ras_ni};

  edo_strobe_sampler #(.W(NSTB)) u_sampler (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_ni(stb_n),
    .prev_o   (stb_prev)
  );

  assign ras_prev = stb_prev[0];
  assign cas_prev = stb_prev[2:1];
  assign we_prev  = stb_prev[3];
  assign cas_n    = {cash_ni, casl_ni};
  assign ras_fall = ras_prev & ~ras_ni;
  assign we_fall  = we_prev & ~we_ni;
  assign cas_fall = cas_prev & ~cas_n & {LANES{~ras_ni}};

  // first strobe of a column cycle carries the column address
  assign col_load  = ~ras_ni & (&cas_prev) & ~(&cas_n);
  assign precharge = &cas_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
    end else begin
      if (ras_fall) row_q <= addr_i[ROW_W-1:0];
      if (col_load) col_q <= addr_i[COL_W-1:0];
    end
  end

  assign row_eff  = ras_fall ? addr_i[ROW_W-1:0] : row_q;
  assign col_eff  = col_load ? addr_i[COL_W-1:0] : col_q;
  assign acc_addr = {row_eff, col_eff};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] mem_rd, rd_data;
    logic              wr_en;

    edo_lane_bank #(.AW(AW), .DW(BYTE_W)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_en_i(wr_en),
      .addr_i (acc_addr),
      .wdata_i(dq_i[g*BYTE_W +: BYTE_W]),
      .rdata_o(mem_rd)
    );

    edo_lane_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ras_ni     (ras_ni),
      .cas_ni     (cas_n[g]),
      .cas_fall_i (cas_fall[g]),
      .we_ni      (we_ni),
      .we_fall_i  (we_fall),
      .oe_ni      (oe_ni),
      .precharge_i(precharge),
      .peer_mode_i(lane_mode[LANES-1-g]),
      .mem_rd_i   (mem_rd),
      .mode_o     (lane_mode[g]),
      .wr_en_o    (wr_en),
      .conflict_o (conflict[g]),
      .drive_o    (drive[g]),
      .rd_data_o  (rd_data)
    );

    assign dq_o[g*BYTE_W +: BYTE_W] = drive[g] ? rd_data : '0;
  end

  assign dq_oe_o = drive;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        proto_err_o <= 1'b0;
    else if (|conflict) proto_err_o <= 1'b1;
  end

  p_row_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_ni && !ras_prev) |=> $stable(row_q));

  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> proto_err_o);

  p_ras_high_hiz_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ras_prev |-> (dq_oe_o == '0 || !ras_ni));
endmodule

// File: tb/edo_dram_emu_tb.sv
`timescale 1ns/1ps
module edo_dram_emu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ras_n = 1'b1, casl_n = 1'b1, cash_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [3:0]  addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe;
  logic        err;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  edo_dram_emu u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .casl_ni(casl_n), .cash_ni(cash_n),
    .we_ni(we_n), .oe_ni(oe_n), .addr_i(addr), .dq_i(dq_in),
    .dq_o(dq_out), .dq_oe_o(dq_oe), .proto_err_o(err)
  );

  // {row, col, data}
  localparam logic [23:0] VEC [8] = '{
    {4'd1, 4'd2, 16'hA5C3}, {4'd1, 4'd3, 16'h0F0F}, {4'd2, 4'd0, 16'hFFFF},
    {4'd4, 4'd7, 16'h1234}, {4'd7, 4'd15, 16'h8001}, {4'd15, 4'd15, 16'hBEEF},
    {4'd0, 4'd0, 16'h5A5A}, {4'd9, 4'd4, 16'hC001}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic open_row(input logic [3:0] row);
    addr = row; ras_n = 1'b0; tick();
  endtask

  task automatic close_row();
    ras_n = 1'b1; casl_n = 1'b1; cash_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; tick();
  endtask

  task automatic wr_early(input logic [3:0] row, input logic [3:0] col,
                          input logic [15:0] d, input logic [1:0] lanes,
                          output logic [1:0] en);
    open_row(row);
    addr = col; dq_in = d; we_n = 1'b0; oe_n = 1'b0;
    casl_n = ~lanes[0]; cash_n = ~lanes[1]; tick();
    en = dq_oe;
    close_row();
  endtask

  task automatic rd_word(input logic [3:0] row, input logic [3:0] col,
                         output logic [15:0] d, output logic [1:0] en);
    open_row(row);
    addr = col; we_n = 1'b1; oe_n = 1'b0; casl_n = 1'b0; cash_n = 1'b0; tick();
    d = dq_out; en = dq_oe;
    close_row();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin : stim
    logic [15:0] d;
    logic [1:0]  en;
    repeat (3) tick();
    chk("R1 reset oe", dq_oe, 0);
    chk("R1 reset dq", dq_out, 0);
    chk("R1 reset err", err, 0);
    rst_n = 1'b1; tick();
    rd_word(4'd3, 4'd5, d, en);
    chk("R1 cleared word", d, 0);
    chk("R1 read lanes", en, 2'b11);

    // table: early-write each vector, then read all back
    for (int i = 0; i < 8; i++) begin
      wr_early(VEC[i][23:20], VEC[i][19:16], VEC[i][15:0], 2'b11, en);
      chk("R5 early write hi-z with oe low", en, 0);
    end
    for (int i = 0; i < 8; i++) begin
      rd_word(VEC[i][23:20], VEC[i][19:16], d, en);
      chk("R2 R3 table readback", d, VEC[i][15:0]);
      chk("R3 table lanes", en, 2'b11);
    end

    // R4 R11 lower-only read
    open_row(4'd1);
    addr = 4'd2; we_n = 1'b1; oe_n = 1'b0; casl_n = 1'b0; tick();
    chk("R4 lower lane only", dq_oe, 2'b01);
    chk("R11 idle lane zero", dq_out, 16'h00C3);
    close_row();

    // R9 oe toggle, R8 hold, R2 page mode
    open_row(4'd1);
    addr = 4'd3; we_n = 1'b1; oe_n = 1'b0; casl_n = 1'b0; cash_n = 1'b0; tick();
    chk("R3 word read", dq_out, 16'h0F0F);
    oe_n = 1'b1; tick();
    chk("R9 oe high hi-z", dq_oe, 0);
    oe_n = 1'b0; tick();
    chk("R9 oe low drives", dq_out, 16'h0F0F);
    casl_n = 1'b1; cash_n = 1'b1; tick();
    chk("R8 held after cas rise", dq_out, 16'h0F0F);
    chk("R8 held lanes", dq_oe, 2'b11);
    addr = 4'd2; casl_n = 1'b0; cash_n = 1'b0; tick();
    chk("R2 page mode new column", dq_out, 16'hA5C3);
    casl_n = 1'b1; cash_n = 1'b1; tick();
    we_n = 1'b0; tick();
    chk("R8 released by we low", dq_oe, 0);
    close_row();

    open_row(4'd2);
    addr = 4'd0; we_n = 1'b1; oe_n = 1'b0; casl_n = 1'b0; cash_n = 1'b0; tick();
    casl_n = 1'b1; cash_n = 1'b1; tick();
    chk("R8 held before ras rise", dq_out, 16'hFFFF);
    ras_n = 1'b1; tick();
    chk("R8 released by ras rise", dq_oe, 0);
    close_row();

    // R4 R5 upper-only early write
    wr_early(4'd4, 4'd7, 16'h9900, 2'b10, en);
    rd_word(4'd4, 4'd7, d, en);
    chk("R4 upper byte write only", d, 16'h9934);

    // R6 late write
    open_row(4'd3);
    addr = 4'd1; we_n = 1'b1; oe_n = 1'b1; casl_n = 1'b0; cash_n = 1'b0; tick();
    we_n = 1'b0; dq_in = 16'h7E81; tick();
    chk("R6 late write hi-z", dq_oe, 0);
    close_row();
    rd_word(4'd3, 4'd1, d, en);
    chk("R6 late write stored", d, 16'h7E81);

    // R7 refused late write
    open_row(4'd3);
    addr = 4'd1; we_n = 1'b1; oe_n = 1'b0; casl_n = 1'b0; cash_n = 1'b0; tick();
    we_n = 1'b0; dq_in = 16'h0000; tick();
    chk("R7 keeps driving", dq_oe, 2'b11);
    chk("R7 drives stored", dq_out, 16'h7E81);
    close_row();
    rd_word(4'd3, 4'd1, d, en);
    chk("R7 no write", d, 16'h7E81);

    // R10 mixed modes separated by precharge
    open_row(4'd5);
    addr = 4'd6; we_n = 1'b1; oe_n = 1'b1; casl_n = 1'b0; tick();
    we_n = 1'b0; dq_in = 16'h0011; tick();
    casl_n = 1'b1; tick();
    addr = 4'd6; cash_n = 1'b0; dq_in = 16'h2200; tick();
    chk("R10 precharge allows mix", err, 0);
    close_row();
    rd_word(4'd5, 4'd6, d, en);
    chk("R10 both bytes written", d, 16'h2211);

    // R10 conflict in one column cycle
    open_row(4'd6);
    addr = 4'd2; we_n = 1'b1; oe_n = 1'b1; casl_n = 1'b0; tick();
    we_n = 1'b0; dq_in = 16'h0033; tick();
    cash_n = 1'b0; dq_in = 16'h4400; tick();
    chk("R10 conflict flagged", err, 1);
    close_row();
    rd_word(4'd6, 4'd2, d, en);
    chk("R10 conflicting byte dropped", d, 16'h0033);
    chk("R10 flag sticky", err, 1);

    finish_run();
  end
endmodule